// File: doc/BRIEF.md
# Multi-Cycle Integer Core

This block is a small integer processor core that runs one instruction at a time. Every instruction passes through five phases in a fixed order: fetch, decode with register read, execute or address calculation, memory access with branch commit, and write-back. Values move between phases through internal holding registers: the instruction word, the next sequential PC, two operands, the immediate, the ALU result, the branch condition and the loaded data word. A new fetch starts only after the previous write-back has finished.

The core has a 32-entry, 32-bit register file. It reads instructions through a combinational instruction memory port and uses a combinational-read, clocked-write data memory port. It supports register-register arithmetic and logic, register-immediate arithmetic and logic, word loads, word stores and a branch taken when a register is zero. A system around the core provides the two memories. It releases a synchronous active-high reset, and execution then starts at address zero.

Top module: `mc_core`

## Requirements
- R1: In the fetch phase the core latches the instruction memory word at PC, presented on imem_addr. It also forms NPC = PC + 4, so straight-line code is fetched at addresses 0, 4, 8, and so on.
- R2: In the decode phase operand A is read from register rs (bits 25:21) and operand B from register rt (bits 20:16). The immediate is bits 15:0 sign-extended to 32 bits, and every immediate form uses this value.
- R3: For loads and stores the effective address is A + immediate, which allows negative offsets. A store drives B on dmem_wdata and pulses dmem_we for one cycle, in the memory phase only.
- R4: Opcode 0x00 selects a register-register operation by the function field in bits 5:0. The codes are ADD 0x20, SUB 0x22, AND 0x24, OR 0x25 and signed set-less-than 0x2A, which gives 1 or 0.
- R5: Register-immediate opcodes apply their operation to A and the sign-extended immediate. The codes are ADDI 0x08, SLTI 0x0A (signed), ANDI 0x0C and ORI 0x0D.
- R6: Opcode 0x04 is branch-if-zero on rs. The execute phase computes the target NPC + (immediate << 2) and sets the condition when A is zero. PC changes only at the end of the memory phase: it takes the target if the branch is taken and NPC otherwise. Backward offsets are allowed.
- R7: A load (0x23) reads the data memory at the effective address in the memory phase, pulsing dmem_re, and writes that word to rt in write-back. A store uses opcode 0x2B. dmem_we and dmem_re are never high together.
- R8: Register-register results go to rd (bits 15:11) and register-immediate results to rt. Stores and branches write no register.
- R9: Each instruction takes exactly 5 clock cycles. After reset is released, the memory phase of the n-th executed instruction (counting from 0) occupies cycle 5n+3.
- R10: Register 0 always reads as zero, and writes to it are ignored.
- R11: An unrecognised opcode, or an unrecognised function code under opcode 0x00, completes in 5 cycles. It writes no register, touches no memory, and only advances PC to NPC.
- R12: A synchronous active-high reset sets PC to 0, puts the core in the fetch phase and holds both data memory strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle in the memory phase |
| dmem_re | output | 1 | Load strobe, one cycle in the memory phase |
| dmem_rdata | input | 32 | Data word at dmem_addr, combinational |

## Verification
In the memory phase the core commits the PC redirect or advance and also performs the data access, so a store's write strobe and the PC update land in the same cycle. The bench runs a program whose stores sit directly after branches. It checks each store's address, data and cycle against the 5n+3 schedule, and then checks the fetch address in the following instruction slot. The branches reuse a register that a later store writes out, so a branch that wrongly writes back, or a redirect taken in the wrong phase, shows up as wrong store data, a wrong store cycle or a wrong fetch address.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;
    localparam int NREGS   = 1 << REG_AW;
    localparam int INSTR_B = XLEN / 8;

    localparam logic [5:0] OP_RR   = 6'h00;
    localparam logic [5:0] OP_BRZ  = 6'h04;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SLTI = 6'h0A;
    localparam logic [5:0] OP_ANDI = 6'h0C;
    localparam logic [5:0] OP_ORI  = 6'h0D;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        PH_IF  = 3'd0,
        PH_ID  = 3'd1,
        PH_EX  = 3'd2,
        PH_MEM = 3'd3,
        PH_WB  = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_RR,
        K_RI,
        K_LD,
        K_ST,
        K_BR
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        phase_e            phase;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   ir;
        logic [XLEN-1:0]   npc;
        logic [XLEN-1:0]   opa;
        logic [XLEN-1:0]   opb;
        logic [XLEN-1:0]   imm;
        logic [XLEN-1:0]   res;
        logic              cond;
        logic [XLEN-1:0]   ldata;
    } core_st_t;

    localparam core_st_t CORE_RST = '{
        phase: PH_IF,
        pc:    '0,
        ir:    '0,
        npc:   '0,
        opa:   '0,
        opb:   '0,
        imm:   '0,
        res:   '0,
        cond:  1'b0,
        ldata: '0
    };

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    localparam int N = 1 << AW;

    logic [W-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (wr_en && (wr_addr != '0) && (wr_addr == AW'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_a = (ra_a == '0) ? '0 : mem_q[ra_a];
        rd_b = (ra_b == '0) ? '0 : mem_q[ra_b];
    end

endmodule

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output kind_e      kind,
    output alu_op_e    alu_op
);
    always_comb begin
        kind   = K_NOP;
        alu_op = ALU_ADD;
        unique case (opcode)
            OP_RR: begin
                kind = K_RR;
                unique case (funct)
                    FN_ADD:  alu_op = ALU_ADD;
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: kind   = K_NOP;
                endcase
            end
            OP_ADDI: begin kind = K_RI; alu_op = ALU_ADD; end
            OP_SLTI: begin kind = K_RI; alu_op = ALU_SLT; end
            OP_ANDI: begin kind = K_RI; alu_op = ALU_AND; end
            OP_ORI:  begin kind = K_RI; alu_op = ALU_OR;  end
            OP_LW:   kind = K_LD;
            OP_SW:   kind = K_ST;
            OP_BRZ:  kind = K_BR;
            default: kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r
);
    logic lt;

    always_comb begin
        lt = $signed(x) < $signed(y);
        unique case (op)
            ALU_ADD: r = x + y;
            ALU_SUB: r = x - y;
            ALU_AND: r = x & y;
            ALU_OR:  r = x | y;
            ALU_SLT: r = {{(W-1){1'b0}}, lt};
            default: r = x + y;
        endcase
    end

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [XLEN-1:0]  imem_addr,
    input  logic [XLEN-1:0]  imem_rdata,
    output logic [XLEN-1:0]  dmem_addr,
    output logic [XLEN-1:0]  dmem_wdata,
    output logic             dmem_we,
    output logic             dmem_re,
    input  logic [XLEN-1:0]  dmem_rdata
);
    localparam int IMM_W = 16;

    core_st_t st_d, st_q;

    kind_e           kind;
    alu_op_e         dec_op;
    alu_op_e         alu_op;
    logic [XLEN-1:0] alu_x, alu_y, alu_r;
    logic [XLEN-1:0] rs_data, rt_data;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic            wb_en;
    logic [XLEN-1:0] wb_data;
    phase_e          phase_q;
    logic            is_br;

    assign rs_idx  = st_q.ir[25:21];
    assign rt_idx  = st_q.ir[20:16];
    assign rd_idx  = st_q.ir[15:11];
    assign phase_q = st_q.phase;
    assign is_br   = (kind == K_BR);

    mc_decode u_dec (
        .opcode (st_q.ir[31:26]),
        .funct  (st_q.ir[5:0]),
        .kind   (kind),
        .alu_op (dec_op)
    );

    mc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk     (clk),
        .ra_a    (rs_idx),
        .ra_b    (rt_idx),
        .rd_a    (rs_data),
        .rd_b    (rt_data),
        .wr_en   (wb_en),
        .wr_addr (wb_idx),
        .wr_data (wb_data)
    );

    // Operand selection for the execute phase: branches add the scaled
    // offset to NPC, memory ops add the offset to A.
    always_comb begin
        alu_x  = st_q.opa;
        alu_y  = st_q.imm;
        alu_op = ALU_ADD;
        unique case (kind)
            K_RR:    begin alu_y = st_q.opb; alu_op = dec_op; end
            K_RI:    alu_op = dec_op;
            K_BR:    begin alu_x = st_q.npc; alu_y = st_q.imm << 2; end
            default: ;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .op (alu_op),
        .x  (alu_x),
        .y  (alu_y),
        .r  (alu_r)
    );

    // Write-back steering.
    always_comb begin
        wb_en   = 1'b0;
        wb_idx  = rt_idx;
        wb_data = st_q.res;
        if (st_q.phase == PH_WB) begin
            unique case (kind)
                K_RR:    begin wb_en = 1'b1; wb_idx = rd_idx; end
                K_RI:    wb_en = 1'b1;
                K_LD:    begin wb_en = 1'b1; wb_data = st_q.ldata; end
                default: wb_en = 1'b0;
            endcase
        end
    end

    // Phase sequencer and inter-phase transfers.
    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IF: begin
                st_d.ir    = imem_rdata;
                st_d.npc   = st_q.pc + XLEN'(INSTR_B);
                st_d.phase = PH_ID;
            end
            PH_ID: begin
                st_d.opa   = rs_data;
                st_d.opb   = rt_data;
                st_d.imm   = {{(XLEN-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
                st_d.phase = PH_EX;
            end
            PH_EX: begin
                st_d.res   = alu_r;
                st_d.cond  = (st_q.opa == '0);
                st_d.phase = PH_MEM;
            end
            PH_MEM: begin
                st_d.pc = (is_br && st_q.cond) ? st_q.res : st_q.npc;
                if (kind == K_LD) begin
                    st_d.ldata = dmem_rdata;
                end
                st_d.phase = PH_WB;
            end
            PH_WB: begin
                st_d.phase = PH_IF;
            end
            default: begin
                st_d.phase = PH_IF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = st_q.res;
    assign dmem_wdata = st_q.opb;
    assign dmem_we    = (st_q.phase == PH_MEM) && (kind == K_ST);
    assign dmem_re    = (st_q.phase == PH_MEM) && (kind == K_LD);

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input phase_e            phase,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   npc,
    input logic [XLEN-1:0]   res,
    input logic              cond,
    input logic              is_br,
    input logic              dmem_we,
    input logic              dmem_re,
    input logic [REG_AW-1:0] rs_idx,
    input logic [XLEN-1:0]   rs_data
);
    p_fetch_npc_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IF) |=> (npc == $past(pc) + 32'd4));

    p_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_MEM) |=> $stable(pc));

    p_taken_target_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MEM && is_br && cond) |=> (pc == $past(res)));

    p_strobe_phase_r7: assert property (@(posedge clk) disable iff (rst)
        (dmem_we || dmem_re) |-> (phase == PH_MEM));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dmem_we, dmem_re}));

    p_wb_to_if_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WB) |=> (phase == PH_IF));

    p_if_to_id_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IF) |=> (phase == PH_ID));

    p_r0_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |-> (rs_data == '0));

    p_reset_state_r12: assert property (@(posedge clk)
        rst |=> (phase == PH_IF && pc == '0 && !dmem_we && !dmem_re));

endmodule

bind mc_core mc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase_q),
    .pc      (imem_addr),
    .npc     (st_q.npc),
    .res     (dmem_addr),
    .cond    (st_q.cond),
    .is_br   (is_br),
    .dmem_we (dmem_we),
    .dmem_re (dmem_re),
    .rs_idx  (rs_idx),
    .rs_data (rs_data)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [95:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_re    (dmem_re),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        if (rst) cyc <= 0; else cyc <= cyc + 1;
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected store of exec index n
    task automatic expect_store(input string tag, input int addr, input logic [31:0] data, input int n);
        exp_q.push_back({32'(addr), data, 32'(5*n+3)});
        tag_q.push_back(tag);
    endtask

    // Monitor: pops on each store strobe and compares address, data, cycle
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R3: unexpected store addr 0x%08h data 0x%08h at cycle %0d", dmem_addr, dmem_wdata, cyc);
            end else begin
                logic [95:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " addr"}, dmem_addr, e[95:64]);
                check({t, " data"}, dmem_wdata, e[63:32]);
                check({t, " R9 cycle"}, 32'(cyc), e[31:0]);
            end
        end
        if (!rst && cyc == 5)   check("R1 sequential fetch", imem_addr, 32'd4);
        if (!rst && cyc == 145) check("R6 taken redirect", imem_addr, 32'd124);
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = enc_i(6'h3F, 0, 0, 0);
            dmem[i] = 32'h0;
        end
        imem[0]  = enc_i(6'h08, 0, 1, 5);
        imem[1]  = enc_i(6'h08, 0, 2, -3);
        imem[2]  = enc_r(6'h20, 1, 2, 3);
        imem[3]  = enc_i(6'h2B, 0, 3, 0);
        imem[4]  = enc_r(6'h22, 1, 2, 4);
        imem[5]  = enc_i(6'h2B, 0, 4, 4);
        imem[6]  = enc_r(6'h24, 1, 2, 5);
        imem[7]  = enc_r(6'h25, 1, 2, 6);
        imem[8]  = enc_i(6'h2B, 0, 5, 8);
        imem[9]  = enc_i(6'h2B, 0, 6, 12);
        imem[10] = enc_r(6'h2A, 2, 1, 7);
        imem[11] = enc_r(6'h2A, 1, 2, 8);
        imem[12] = enc_i(6'h2B, 0, 7, 16);
        imem[13] = enc_i(6'h2B, 0, 8, 20);
        imem[14] = enc_i(6'h0C, 1, 9, -1);
        imem[15] = enc_i(6'h0D, 0, 10, 16'h8000);
        imem[16] = enc_i(6'h0A, 2, 11, 0);
        imem[17] = enc_i(6'h2B, 0, 9, 24);
        imem[18] = enc_i(6'h2B, 0, 10, 28);
        imem[19] = enc_i(6'h2B, 0, 11, 32);
        imem[20] = enc_i(6'h23, 0, 12, 4);
        imem[21] = enc_i(6'h23, 4, 13, -4);
        imem[22] = enc_r(6'h20, 12, 13, 14);
        imem[23] = enc_i(6'h2B, 0, 14, 36);
        imem[24] = enc_i(6'h08, 0, 0, 7);
        imem[25] = enc_i(6'h2B, 0, 0, 40);
        imem[26] = enc_i(6'h04, 1, 1, 5);
        imem[27] = enc_i(6'h2B, 0, 1, 44);
        imem[28] = enc_i(6'h04, 0, 2, 2);
        imem[29] = enc_i(6'h2B, 0, 1, 48);
        imem[30] = enc_i(6'h2B, 0, 1, 52);
        imem[31] = enc_i(6'h2B, 0, 2, 48);
        imem[32] = enc_i(6'h3F, 3, 3, 100);
        imem[33] = enc_i(6'h2B, 0, 11, 52);
        imem[34] = enc_i(6'h04, 0, 0, -1);

        expect_store("R4 ADD",               0,  32'd2,         3);
        expect_store("R4 SUB",               4,  32'd8,         5);
        expect_store("R4 AND",               8,  32'd5,         8);
        expect_store("R4 OR",                12, 32'hFFFFFFFD,  9);
        expect_store("R4 SLT true",          16, 32'd1,         12);
        expect_store("R4 SLT false",         20, 32'd0,         13);
        expect_store("R5 ANDI sext",         24, 32'd5,         17);
        expect_store("R2 R5 ORI sext",       28, 32'hFFFF8000,  18);
        expect_store("R5 SLTI",              32, 32'd1,         19);
        expect_store("R3 R7 LW neg offset",  36, 32'd16,        23);
        expect_store("R10 r0 write ignored", 40, 32'd0,         25);
        expect_store("R6 R8 not taken",      44, 32'd5,         27);
        expect_store("R6 R8 taken",          48, 32'hFFFFFFFD,  29);
        expect_store("R11 unknown opcode",   52, 32'd1,         31);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset pc", imem_addr, 32'd0);
        check("R12 reset no store", {31'd0, dmem_we}, 32'd0);
        check("R12 reset no load", {31'd0, dmem_re}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < WATCHDOG; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        if (exp_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R9: watchdog expired, %0d stores outstanding (actual) vs 0 expected", exp_q.size());
        end else begin
            repeat (20) @(negedge clk);
            check("R6 backward branch loop", imem_addr, 32'd136);
            check("R7 load data word", dmem[9], 32'd16);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule